// File: doc/BRIEF.md
# Page Translation Buffer with Access Tracking

This block sits beside the processor and holds a handful of recent page-to-frame mappings so that most memory references are translated without a page-table lookup. A request carries a virtual page number, an offset and an access kind (read, write or instruction fetch). The block answers with a physical address made from the cached frame number and the unchanged offset. Otherwise it answers with one of three outcomes: a miss, a page fault for a mapping whose present flag is clear, or a protection violation.

Each slot keeps the mapping, a present flag, a two-bit protection code, and dirty and used flags that are updated by the accesses that succeed. An external walker supplies refills. When a refill displaces an occupied slot, the displaced page number and its dirty and used flags are presented for one cycle, so that the page-table state can be brought up to date. A flush input empties every slot, and an invalidate input removes one page.

Top module: `tlb_xlate`

## Requirements
- R1: On a successful lookup, resp_paddr is {frame, offset}, with the offset bits passed through unchanged. For example, page 3 mapped to frame 459 and offset 881 gives {20'd459, 12'd881}.
- R2: One request is held at a time. The outcome flag for an accepted request appears in the cycle after acceptance. req_ready is high when nothing is held, or when the held request completes (hit, fault or violation) in that cycle.
- R3: A lookup that matches no slot raises resp_miss for exactly one cycle. The request is then kept, with req_ready low, until the next refill write. In the cycle after that refill the lookup is repeated.
- R4: A matching slot whose present flag is 0 gives resp_fault, a resp_paddr of 0, and no change to its used or dirty flags.
- R5: A successful write (req_type 2'b01) sets the slot's dirty flag. A refill clears the dirty flag.
- R6: Any successful access sets the slot's used flag. A refill clears the used flag.
- R7: Protection codes are 2'b00 read-only, 2'b01 read/write, 2'b10 execute-only and 2'b11 read/execute. Access kinds are 2'b00 read, 2'b01 write and 2'b10 fetch, and 2'b11 is always rejected. A disallowed access gives resp_perr, a resp_paddr of 0, and no flag changes. Any read or write to an execute-only page is rejected.
- R8: A refill goes to the slot already holding that page if there is one, otherwise to the lowest free slot, otherwise to the slot under a rotating pointer. The pointer starts at 0 and advances by one, wrapping, only for the last case.
- R9: When a refill lands on an occupied slot, wb_valid is high in the following cycle, with that slot's old page number, dirty flag and used flag. A refill into a free slot gives no write-back.
- R10: flush empties every slot at one clock edge, and it takes precedence over a refill at the same edge.
- R11: inval_valid removes only the slot that holds inval_vpn. All other mappings keep working.
- R12: Out of reset, req_ready is 1, all outcome flags are 0 and wb_valid is 0. At most one outcome flag is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_type | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| req_vpn | input | 20 | Virtual page number |
| req_off | input | 12 | Page offset |
| resp_hit | output | 1 | Translation succeeded |
| resp_miss | output | 1 | No slot holds the page |
| resp_fault | output | 1 | Mapping not present |
| resp_perr | output | 1 | Access kind not allowed |
| resp_paddr | output | 32 | Physical address, zero unless hit |
| fill_valid | input | 1 | Refill write |
| fill_vpn | input | 20 | Refill page number |
| fill_pfn | input | 20 | Refill frame number |
| fill_present | input | 1 | Refill present flag |
| fill_prot | input | 2 | Refill protection code |
| flush | input | 1 | Empty all slots |
| inval_valid | input | 1 | Remove one page |
| inval_vpn | input | 20 | Page to remove |
| wb_valid | output | 1 | Displaced slot report valid |
| wb_vpn | output | 20 | Displaced page number |
| wb_dirty | output | 1 | Displaced dirty flag |
| wb_used | output | 1 | Displaced used flag |

## Verification
Outcome flags and the address are due in the cycle after a request is accepted. A missed request is retried, and its result is due in the cycle after the refill edge. The write-back report is due in the cycle after the refill edge that displaces a slot, while flush and invalidate take effect on lookups starting from the next cycle. The bench drives its inputs just after the rising edge and samples every output at the falling edge. A behavioural model steps through the same edges and predicts each of these cycles, and directed sequences wait exactly one edge after acceptance or refill before reading the flags and the write-back fields.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  localparam logic [1:0] PR_RO = 2'b00;
  localparam logic [1:0] PR_RW = 2'b01;
  localparam logic [1:0] PR_XO = 2'b10;
  localparam logic [1:0] PR_RX = 2'b11;

  typedef enum logic [2:0] {
    OUT_NONE  = 3'd0,
    OUT_HIT   = 3'd1,
    OUT_MISS  = 3'd2,
    OUT_FAULT = 3'd3,
    OUT_PERR  = 3'd4
  } outcome_e;

  // Permission decision for one protection code and one access kind
  function automatic logic perm_ok(input logic [1:0] prot, input logic [1:0] acc);
    logic ok;
    case (acc)
      ACC_READ:  ok = (prot == PR_RO) || (prot == PR_RW) || (prot == PR_RX);
      ACC_WRITE: ok = (prot == PR_RW);
      ACC_FETCH: ok = (prot == PR_XO) || (prot == PR_RX);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  output logic [N-1:0]     look_match,
  output logic [PFN_W-1:0] look_pfn,
  output logic             look_present,
  output logic [1:0]       look_prot,
  input  logic             touch_en,
  input  logic             touch_write,
  input  logic [VPN_W-1:0] fill_vpn,
  output logic [N-1:0]     fill_match,
  output logic [N-1:0]     live,
  input  logic             fill_en,
  input  logic [N-1:0]     fill_slot,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_present,
  input  logic [1:0]       fill_prot,
  output logic [VPN_W-1:0] ev_vpn,
  output logic             ev_dirty,
  output logic             ev_used,
  output logic             ev_live,
  input  logic             flush,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn
);
  logic [VPN_W-1:0] e_vpn   [N];
  logic [PFN_W-1:0] e_pfn   [N];
  logic [1:0]       e_prot  [N];
  logic [N-1:0]     e_live;
  logic [N-1:0]     e_pres;
  logic [N-1:0]     e_dirty;
  logic [N-1:0]     e_used;
  logic [N-1:0]     inv_hit;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign look_match[g] = e_live[g] && (e_vpn[g] == look_vpn);
      assign fill_match[g] = e_live[g] && (e_vpn[g] == fill_vpn);
      assign inv_hit[g]    = e_live[g] && (e_vpn[g] == inv_vpn);
    end
  endgenerate

  assign live = e_live;

  always_comb begin
    look_pfn     = '0;
    look_present = 1'b0;
    look_prot    = 2'b00;
    ev_vpn       = '0;
    ev_dirty     = 1'b0;
    ev_used      = 1'b0;
    ev_live      = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (look_match[i]) begin
        look_pfn     = look_pfn | e_pfn[i];
        look_present = look_present | e_pres[i];
        look_prot    = look_prot | e_prot[i];
      end
      if (fill_slot[i]) begin
        ev_vpn   = ev_vpn | e_vpn[i];
        ev_dirty = ev_dirty | e_dirty[i];
        ev_used  = ev_used | e_used[i];
        ev_live  = ev_live | e_live[i];
      end
    end
  end

  // Per-slot update priority: flush, invalidate, refill, access tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        e_live[i]  <= 1'b0;
        e_pres[i]  <= 1'b0;
        e_dirty[i] <= 1'b0;
        e_used[i]  <= 1'b0;
        e_vpn[i]   <= '0;
        e_pfn[i]   <= '0;
        e_prot[i]  <= 2'b00;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush) begin
          e_live[i] <= 1'b0;
        end else if (inv_en && inv_hit[i]) begin
          e_live[i] <= 1'b0;
        end else if (fill_en && fill_slot[i]) begin
          e_live[i]  <= 1'b1;
          e_vpn[i]   <= fill_vpn;
          e_pfn[i]   <= fill_pfn;
          e_pres[i]  <= fill_present;
          e_prot[i]  <= fill_prot;
          e_dirty[i] <= 1'b0;
          e_used[i]  <= 1'b0;
        end else if (touch_en && look_match[i]) begin
          e_used[i] <= 1'b1;
          if (touch_write) e_dirty[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] live,
  input  logic [N-1:0] fill_match,
  input  logic         fill_en,
  input  logic         blocked,
  output logic [N-1:0] slot,
  output logic         rotate
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] ptr;
  logic [N-1:0]     free_oh;
  logic             any_free;

  always_comb begin
    free_oh  = '0;
    any_free = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!live[i] && !any_free) begin
        free_oh[i] = 1'b1;
        any_free   = 1'b1;
      end
    end
    if (|fill_match)   slot = fill_match;
    else if (any_free) slot = free_oh;
    else               slot = N'(1) << ptr;
  end

  assign rotate = fill_en && !blocked && !(|fill_match) && !any_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (rotate) ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_type,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  output logic                   resp_hit,
  output logic                   resp_miss,
  output logic                   resp_fault,
  output logic                   resp_perr,
  output logic [PFN_W+OFF_W-1:0] resp_paddr,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic                   fill_present,
  input  logic [1:0]             fill_prot,
  input  logic                   flush,
  input  logic                   inval_valid,
  input  logic [VPN_W-1:0]       inval_vpn,
  output logic                   wb_valid,
  output logic [VPN_W-1:0]       wb_vpn,
  output logic                   wb_dirty,
  output logic                   wb_used
);
  import tlb_pkg::*;

  localparam int PA_W = PFN_W + OFF_W;

  function automatic logic [PA_W-1:0] make_pa(input logic [PFN_W-1:0] f,
                                              input logic [OFF_W-1:0] o);
    return {f, o};
  endfunction

  // Held request
  logic             hold_vld, hold_wait;
  logic [VPN_W-1:0] hold_vpn;
  logic [OFF_W-1:0] hold_off;
  logic [1:0]       hold_type;

  // Named internal events
  logic               look_act, look_any, look_allow, look_done, accept;
  logic [ENTRIES-1:0] look_match, fill_match, live, fill_slot;
  logic [PFN_W-1:0]   look_pfn;
  logic               look_present;
  logic [1:0]         look_prot;
  logic [VPN_W-1:0]   ev_vpn;
  logic               ev_dirty, ev_used, ev_live, rotate;

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
    .clk          (clk),
    .rst_n        (rst_n),
    .look_vpn     (hold_vpn),
    .look_match   (look_match),
    .look_pfn     (look_pfn),
    .look_present (look_present),
    .look_prot    (look_prot),
    .touch_en     (resp_hit),
    .touch_write  (hold_type == ACC_WRITE),
    .fill_vpn     (fill_vpn),
    .fill_match   (fill_match),
    .live         (live),
    .fill_en      (fill_valid),
    .fill_slot    (fill_slot),
    .fill_pfn     (fill_pfn),
    .fill_present (fill_present),
    .fill_prot    (fill_prot),
    .ev_vpn       (ev_vpn),
    .ev_dirty     (ev_dirty),
    .ev_used      (ev_used),
    .ev_live      (ev_live),
    .flush        (flush),
    .inv_en       (inval_valid),
    .inv_vpn      (inval_vpn)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .live       (live),
    .fill_match (fill_match),
    .fill_en    (fill_valid),
    .blocked    (flush),
    .slot       (fill_slot),
    .rotate     (rotate)
  );

  assign look_act   = hold_vld && !hold_wait;
  assign look_any   = |look_match;
  assign look_allow = perm_ok(look_prot, hold_type);

  assign resp_miss  = look_act && !look_any;
  assign resp_fault = look_act && look_any && !look_present;
  assign resp_perr  = look_act && look_any && look_present && !look_allow;
  assign resp_hit   = look_act && look_any && look_present && look_allow;
  assign resp_paddr = resp_hit ? make_pa(look_pfn, hold_off) : '0;

  assign look_done  = resp_hit || resp_fault || resp_perr;
  assign req_ready  = !hold_vld || look_done;
  assign accept     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_wait <= 1'b0;
      hold_vpn  <= '0;
      hold_off  <= '0;
      hold_type <= ACC_READ;
    end else if (accept) begin
      hold_vld  <= 1'b1;
      hold_wait <= 1'b0;
      hold_vpn  <= req_vpn;
      hold_off  <= req_off;
      hold_type <= req_type;
    end else if (look_done) begin
      hold_vld  <= 1'b0;
    end else if (resp_miss) begin
      hold_wait <= 1'b1;
    end else if (hold_wait && fill_valid) begin
      hold_wait <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_vpn   <= '0;
      wb_dirty <= 1'b0;
      wb_used  <= 1'b0;
    end else if (fill_valid && !flush && ev_live) begin
      wb_valid <= 1'b1;
      wb_vpn   <= ev_vpn;
      wb_dirty <= ev_dirty;
      wb_used  <= ev_used;
    end else begin
      wb_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             resp_hit,
  input logic             resp_miss,
  input logic             resp_fault,
  input logic             resp_perr,
  input logic [PA_W-1:0]  resp_paddr,
  input logic [OFF_W-1:0] hold_off,
  input logic             hold_wait,
  input logic             fill_valid,
  input logic             flush,
  input logic             wb_valid
);
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_hit, resp_miss, resp_fault, resp_perr}));

  a_r3_miss_single: assert property (@(posedge clk) disable iff (!rst_n)
    resp_miss |=> !resp_miss);

  a_r3_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    resp_miss |-> !req_ready);

  a_r2_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wait |-> !req_ready);

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> (resp_paddr[OFF_W-1:0] == hold_off));

  a_r4_fault_noaddr: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> (resp_paddr == '0));

  a_r7_perr_noaddr: assert property (@(posedge clk) disable iff (!rst_n)
    resp_perr |-> (resp_paddr == '0));

  a_r9_wb_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(fill_valid && !flush));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(resp_hit || resp_fault || resp_perr));
endmodule

bind tlb_xlate tlb_xlate_chk #(.OFF_W(OFF_W), .PA_W(PFN_W + OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .resp_hit   (resp_hit),
  .resp_miss  (resp_miss),
  .resp_fault (resp_fault),
  .resp_perr  (resp_perr),
  .resp_paddr (resp_paddr),
  .hold_off   (hold_off),
  .hold_wait  (hold_wait),
  .fill_valid (fill_valid),
  .flush      (flush),
  .wb_valid   (wb_valid)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_type = 2'b00;
  logic [19:0] req_vpn = '0;
  logic [11:0] req_off = '0;
  logic        resp_hit, resp_miss, resp_fault, resp_perr;
  logic [31:0] resp_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        fill_present = 1'b0;
  logic [1:0]  fill_prot = 2'b00;
  logic        flush = 1'b0;
  logic        inval_valid = 1'b0;
  logic [19:0] inval_vpn = '0;
  logic        wb_valid, wb_dirty, wb_used;
  logic [19:0] wb_vpn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_vpn(req_vpn), .req_off(req_off),
    .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_fault(resp_fault),
    .resp_perr(resp_perr), .resp_paddr(resp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_present(fill_present), .fill_prot(fill_prot),
    .flush(flush), .inval_valid(inval_valid), .inval_vpn(inval_vpn),
    .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_dirty(wb_dirty), .wb_used(wb_used)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_live [N];
  logic [19:0] m_vpn  [N];
  logic [19:0] m_pfn  [N];
  bit          m_pres [N];
  logic [1:0]  m_prot [N];
  bit          m_dirty[N];
  bit          m_used [N];
  int          m_ptr;
  bit          ms_vld, ms_wait;
  logic [19:0] ms_vpn;
  logic [11:0] ms_off;
  logic [1:0]  ms_type;
  bit          mw_v, mw_d, mw_u;
  logic [19:0] mw_vpn;

  function automatic int m_find(input logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_live[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic bit m_allowed(input logic [1:0] p, input logic [1:0] a);
    if (a == 2'b00) return p != 2'b10;
    if (a == 2'b01) return p == 2'b01;
    if (a == 2'b10) return p[1];
    return 0;
  endfunction

  // 0 none, 1 hit, 2 miss, 3 fault, 4 violation
  function automatic int m_kind();
    int k;
    if (!ms_vld || ms_wait) return 0;
    k = m_find(ms_vpn);
    if (k < 0) return 2;
    if (!m_pres[k]) return 3;
    if (!m_allowed(m_prot[k], ms_type)) return 4;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_live[i] = 0; m_dirty[i] = 0; m_used[i] = 0; end
      m_ptr = 0; ms_vld = 0; ms_wait = 0; mw_v = 0;
    end else begin
      int k, idx, s;
      bit rdy;
      k = m_kind();
      idx = m_find(ms_vpn);
      rdy = !ms_vld || k == 1 || k == 3 || k == 4;
      s = -1;
      mw_v = 0;
      if (fill_valid && !flush) begin
        s = m_find(fill_vpn);
        if (s < 0) for (int i = N - 1; i >= 0; i--) if (!m_live[i]) s = i;
        if (s < 0) begin s = m_ptr; m_ptr = (m_ptr + 1) % N; end
        if (m_live[s]) begin mw_v = 1; mw_vpn = m_vpn[s]; mw_d = m_dirty[s]; mw_u = m_used[s]; end
      end
      for (int i = 0; i < N; i++) begin
        if (flush) m_live[i] = 0;
        else if (inval_valid && m_live[i] && m_vpn[i] == inval_vpn) m_live[i] = 0;
        else if (i == s) begin
          m_live[i] = 1; m_vpn[i] = fill_vpn; m_pfn[i] = fill_pfn;
          m_pres[i] = fill_present; m_prot[i] = fill_prot; m_dirty[i] = 0; m_used[i] = 0;
        end else if (k == 1 && i == idx) begin
          m_used[i] = 1;
          if (ms_type == 2'b01) m_dirty[i] = 1;
        end
      end
      if (req_valid && rdy) begin
        ms_vld = 1; ms_wait = 0; ms_vpn = req_vpn; ms_off = req_off; ms_type = req_type;
      end else if (k == 1 || k == 3 || k == 4) ms_vld = 0;
      else if (k == 2) ms_wait = 1;
      else if (ms_wait && fill_valid) ms_wait = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int k, idx;
      logic [31:0] pa;
      k = m_kind();
      idx = m_find(ms_vpn);
      pa = (k == 1) ? {m_pfn[idx], ms_off} : 32'd0;
      chk(resp_hit == (k == 1), "R1 hit", resp_hit, k == 1);
      chk(resp_paddr == pa, "R1 paddr", resp_paddr, pa);
      chk(resp_miss == (k == 2), "R3 miss", resp_miss, k == 2);
      chk(resp_fault == (k == 3), "R4 fault", resp_fault, k == 3);
      chk(resp_perr == (k == 4), "R7 perr", resp_perr, k == 4);
      chk(req_ready == (!ms_vld || k == 1 || k == 3 || k == 4), "R2 ready", req_ready,
          !ms_vld || k == 1 || k == 3 || k == 4);
      chk(wb_valid == mw_v, "R9 wb_valid", wb_valid, mw_v);
      if (mw_v) begin
        chk(wb_vpn == mw_vpn, "R9 wb_vpn", wb_vpn, mw_vpn);
        chk(wb_dirty == mw_d, "R5 wb_dirty", wb_dirty, mw_d);
        chk(wb_used == mw_u, "R6 wb_used", wb_used, mw_u);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  int          last_kind;
  logic [31:0] last_pa;
  bit          last_wbv, last_wbd, last_wbu;
  logic [19:0] last_wbvpn;

  function automatic int cur_kind();
    if (resp_hit) return 1;
    if (resp_miss) return 2;
    if (resp_fault) return 3;
    if (resp_perr) return 4;
    return 0;
  endfunction

  task automatic send(input logic [1:0] t, input logic [19:0] v, input logic [11:0] o);
    @(posedge clk); #1;
    req_valid = 1; req_type = t; req_vpn = v; req_off = o;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    last_kind = cur_kind();
    last_pa = resp_paddr;
  endtask

  task automatic refill(input logic [19:0] v, input logic [19:0] f, input bit p,
                        input logic [1:0] pr, input bit with_flush);
    @(posedge clk); #1;
    fill_valid = 1; fill_vpn = v; fill_pfn = f; fill_present = p; fill_prot = pr;
    flush = with_flush;
    @(posedge clk); #1;
    fill_valid = 0; flush = 0;
    @(negedge clk);
    last_wbv = wb_valid; last_wbvpn = wb_vpn; last_wbd = wb_dirty; last_wbu = wb_used;
    last_kind = cur_kind();
    last_pa = resp_paddr;
  endtask

  task automatic pulse_inval(input logic [19:0] v);
    @(posedge clk); #1;
    inval_valid = 1; inval_vpn = v;
    @(posedge clk); #1;
    inval_valid = 0;
  endtask

  task automatic pulse_flush();
    @(posedge clk); #1;
    flush = 1;
    @(posedge clk); #1;
    flush = 0;
  endtask

  task automatic expect_wb(input bit v, input logic [19:0] vpn, input bit d, input bit u,
                           input string tag);
    chk(last_wbv == v, {tag, " wb_valid"}, last_wbv, v);
    if (v) begin
      chk(last_wbvpn == vpn, {tag, " wb_vpn"}, last_wbvpn, vpn);
      chk(last_wbd == d, {tag, " wb_dirty"}, last_wbd, d);
      chk(last_wbu == u, {tag, " wb_used"}, last_wbu, u);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R12 reset ready", req_ready, 1);
    chk(cur_kind() == 0, "R12 reset flags", cur_kind(), 0);
    chk(wb_valid == 0, "R12 reset wb", wb_valid, 0);

    refill(20'd3, 20'd459, 1, 2'b01, 0);
    expect_wb(0, 0, 0, 0, "R8 free slot");
    send(2'b00, 20'd3, 12'd881);
    chk(last_kind == 1, "R1 read hit", last_kind, 1);
    chk(last_pa == {20'd459, 12'd881}, "R1 example address", last_pa, {20'd459, 12'd881});
    send(2'b01, 20'd3, 12'd4);
    chk(last_kind == 1, "R5 write hit", last_kind, 1);

    send(2'b00, 20'd7, 12'h123);
    chk(last_kind == 2, "R3 miss", last_kind, 2);
    @(negedge clk);
    chk(resp_miss == 0, "R3 miss one cycle", resp_miss, 0);
    chk(req_ready == 0, "R3 held", req_ready, 0);
    refill(20'd7, 20'd100, 1, 2'b00, 0);
    chk(last_kind == 1, "R3 retry hit", last_kind, 1);
    chk(last_pa == {20'd100, 12'h123}, "R3 retry address", last_pa, {20'd100, 12'h123});

    refill(20'd9, 20'd55, 0, 2'b01, 0);
    send(2'b00, 20'd9, 12'd1);
    chk(last_kind == 3, "R4 fault", last_kind, 3);
    chk(last_pa == 0, "R4 no address", last_pa, 0);

    refill(20'd10, 20'd66, 1, 2'b10, 0);
    send(2'b00, 20'd10, 12'd2);
    chk(last_kind == 4, "R7 exec-only read", last_kind, 4);
    send(2'b01, 20'd10, 12'd2);
    chk(last_kind == 4, "R7 exec-only write", last_kind, 4);
    send(2'b10, 20'd10, 12'd2);
    chk(last_kind == 1, "R7 exec-only fetch", last_kind, 1);
    send(2'b01, 20'd7, 12'd5);
    chk(last_kind == 4, "R7 read-only write", last_kind, 4);

    for (int i = 11; i <= 14; i++) refill(20'(i), 20'(i + 200), 1, 2'b01, 0);
    refill(20'd20, 20'd1, 1, 2'b01, 0);
    expect_wb(1, 20'd3, 1, 1, "R5 R6 R9 slot0");
    refill(20'd21, 20'd1, 1, 2'b01, 0);
    expect_wb(1, 20'd7, 0, 1, "R6 R7 slot1");
    refill(20'd22, 20'd1, 1, 2'b01, 0);
    expect_wb(1, 20'd9, 0, 0, "R4 slot2");
    refill(20'd23, 20'd1, 1, 2'b01, 0);
    expect_wb(1, 20'd10, 0, 1, "R8 slot3");
    refill(20'd24, 20'd1, 1, 2'b01, 0);
    expect_wb(1, 20'd11, 0, 0, "R8 slot4");

    pulse_inval(20'd12);
    send(2'b00, 20'd12, 12'd7);
    chk(last_kind == 2, "R11 removed page misses", last_kind, 2);
    refill(20'd12, 20'd77, 1, 2'b01, 0);
    expect_wb(0, 0, 0, 0, "R8 freed slot reused");
    chk(last_kind == 1, "R11 refilled hit", last_kind, 1);
    send(2'b00, 20'd13, 12'd8);
    chk(last_kind == 1, "R11 other page kept", last_kind, 1);
    chk(last_pa == {20'd213, 12'd8}, "R11 other address", last_pa, {20'd213, 12'd8});

    refill(20'd13, 20'd99, 1, 2'b11, 0);
    expect_wb(1, 20'd13, 0, 1, "R8 same page slot");
    send(2'b11, 20'd13, 12'd0);
    chk(last_kind == 4, "R7 reserved kind", last_kind, 4);

    pulse_flush();
    send(2'b00, 20'd13, 12'd9);
    chk(last_kind == 2, "R10 flush miss", last_kind, 2);
    refill(20'd13, 20'd5, 1, 2'b11, 0);
    expect_wb(0, 0, 0, 0, "R10 empty after flush");
    chk(last_kind == 1, "R10 refill hit", last_kind, 1);

    refill(20'd30, 20'd6, 1, 2'b01, 1);
    expect_wb(0, 0, 0, 0, "R10 flush with refill");
    send(2'b00, 20'd30, 12'd1);
    chk(last_kind == 2, "R10 flush beats refill", last_kind, 2);
    refill(20'd30, 20'd6, 1, 2'b01, 0);
    chk(last_kind == 1, "R10 retry after flush", last_kind, 1);

    repeat (3) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule